// File: doc/BRIEF.md
# Test Access Port with Configuration Restart

This block is the serial test port of a configuration memory. It contains the sixteen-state test access port controller, an eight-bit instruction register, a one-bit bypass register and a 32-bit identification register. TDI and TMS are sampled on the rising edge of TCK. TDO is updated on the falling edge and is enabled only while an instruction or data register is shifting.

The instruction register does not capture a constant. It loads a status word that carries two device flags, so a host can read the erase/program state and the security state with every instruction scan. One instruction is specific to this block. When it is loaded and the controller enters Run-Test/Idle, the configuration-restart output `cfg_n` goes low for a fixed number of system clock cycles. This resets the attached FPGA and starts its configuration. The request is raised in the TCK domain and timed by a free-running system clock, so the pulse width does not depend on the TCK rate.

Top module: `cfg_tap`

## Requirements
- R1: When `trst` is high at a rising TCK edge, the controller goes to Test-Logic-Reset and the identification instruction becomes active. A data scan that follows then returns the 32-bit identification word.
- R2: From any state, five rising TCK edges with TMS high bring the controller to Test-Logic-Reset and make the identification instruction active, even if another instruction was loaded before.
- R3: At Capture-IR the instruction shifter loads this value: bit 0 = 1, bit 1 = 0, bit 2 = 0, bit 3 = `st_secure`, bit 4 = `st_prog`, and bits 7..5 = 0. It is shifted out on TDO least significant bit first.
- R4: The identification word is {version[3:0], family[7:0], product[7:0], maker[10:0], 1'b1}, from most to least significant bit. It is shifted out LSB first, and TDI bits follow it after 32 shifts.
- R5: The all-ones instruction selects the one-bit bypass register. It captures 0, so in an 8-bit data scan TDO gives 0 and then TDI delayed by one shift.
- R6: Any instruction that is not the identification or restart code behaves as bypass. Example: 8'h5A.
- R7: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR. It is 0 after reset and in every other state.
- R8: Each entry into Run-Test/Idle with the restart instruction (default 8'hEE) active drives `cfg_n` low for exactly PULSE_CYC system clock cycles. This gives one pulse per entry, and staying in Run-Test/Idle does not repeat it.
- R9: `cfg_n` is 1 after reset. Entering Run-Test/Idle with any other instruction gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that times the restart pulse |
| rst | input | 1 | Synchronous active-high reset, system clock domain |
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset, TCK domain |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Test data in, sampled on rising TCK |
| st_secure | input | 1 | Security status flag reported at Capture-IR |
| st_prog | input | 1 | Erase/program status flag reported at Capture-IR |
| tdo | output | 1 | Test data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO |
| cfg_n | output | 1 | Active-low configuration restart pulse |

## Verification
The case that is hardest to reach from the ports is the restart pulse seen across its clock crossing. The stimulus loads the restart code and lets the controller sit in Run-Test/Idle for many TCK cycles. A monitor on the system clock counts both the falling edges of `cfg_n` and the length of each low period. This shows exactly one pulse of the right width. The bench then leaves Run-Test/Idle through a data scan and comes back, to show that each new entry triggers again. The TMS-only return to reset is started partway through a data scan with bypass loaded. The identification word read afterwards proves that the instruction was restored.

// File: rtl/cfgtap_pkg.sv
package cfgtap_pkg;

    typedef enum logic [3:0] {
        TAP_TLR    = 4'h0,
        TAP_RTI    = 4'h1,
        TAP_SEL_DR = 4'h2,
        TAP_CAP_DR = 4'h3,
        TAP_SH_DR  = 4'h4,
        TAP_EX1_DR = 4'h5,
        TAP_PAU_DR = 4'h6,
        TAP_EX2_DR = 4'h7,
        TAP_UPD_DR = 4'h8,
        TAP_SEL_IR = 4'h9,
        TAP_CAP_IR = 4'hA,
        TAP_SH_IR  = 4'hB,
        TAP_EX1_IR = 4'hC,
        TAP_PAU_IR = 4'hD,
        TAP_EX2_IR = 4'hE,
        TAP_UPD_IR = 4'hF
    } tap_st_e;

    typedef enum logic [1:0] {
        SEL_BYP = 2'd0,
        SEL_ID  = 2'd1,
        SEL_CFG = 2'd2
    } dr_sel_e;

    typedef struct packed {
        logic [3:0]  ver;
        logic [7:0]  fam;
        logic [7:0]  prod;
        logic [10:0] maker;
        logic        one;
    } idword_t;

    function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
        tap_st_e n;
        case (s)
            TAP_TLR:    n = m ? TAP_TLR    : TAP_RTI;
            TAP_RTI:    n = m ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_DR: n = m ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR: n = m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:  n = m ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR: n = m ? TAP_UPD_DR : TAP_PAU_DR;
            TAP_PAU_DR: n = m ? TAP_EX2_DR : TAP_PAU_DR;
            TAP_EX2_DR: n = m ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR: n = m ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_IR: n = m ? TAP_TLR    : TAP_CAP_IR;
            TAP_CAP_IR: n = m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:  n = m ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR: n = m ? TAP_UPD_IR : TAP_PAU_IR;
            TAP_PAU_IR: n = m ? TAP_EX2_IR : TAP_PAU_IR;
            TAP_EX2_IR: n = m ? TAP_UPD_IR : TAP_SH_IR;
            default:    n = m ? TAP_SEL_DR : TAP_RTI;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import cfgtap_pkg::*;
(
    input  logic    tck,
    input  logic    trst,
    input  logic    tms,
    output tap_st_e state,
    output tap_st_e nxt
);

    tap_st_e state_q;

    assign nxt   = trst ? TAP_TLR : tap_next(state_q, tms);
    assign state = state_q;

    always_ff @(posedge tck) begin
        if (trst) state_q <= TAP_TLR;
        else      state_q <= tap_next(state_q, tms);
    end

    // count of consecutive TMS-high edges, used only by the check below
    logic [2:0] ones_q;
    always_ff @(posedge tck) begin
        if (trst)            ones_q <= '0;
        else if (!tms)       ones_q <= '0;
        else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
    end

    // R1
    trst_home_chk: assert property (@(posedge tck) trst |=> state_q == TAP_TLR)
        else $error("test reset did not reach Test-Logic-Reset");

    // R2
    tms_home_chk: assert property (@(posedge tck) disable iff (trst)
        (ones_q == 3'd5) |-> state_q == TAP_TLR)
        else $error("five TMS-high edges did not reach Test-Logic-Reset");

endmodule

// File: rtl/tap_regs.sv
module tap_regs
    import cfgtap_pkg::*;
#(
    parameter int              IR_W      = 8,
    parameter logic [IR_W-1:0] OP_IDCODE = 8'h09,
    parameter logic [IR_W-1:0] OP_CFG    = 8'hEE,
    parameter logic [IR_W-1:0] OP_BYPASS = '1,
    parameter logic [31:0]     ID_VAL    = 32'h1
) (
    input  logic    tck,
    input  logic    trst,
    input  logic    tdi,
    input  tap_st_e state,
    input  tap_st_e nxt,
    input  logic    st_secure,
    input  logic    st_prog,
    output logic    tdo,
    output logic    tdo_oe,
    output logic    cfg_req
);

    localparam int ID_W = 32;

    function automatic dr_sel_e decode(input logic [IR_W-1:0] op);
        if (op == OP_IDCODE)      return SEL_ID;
        else if (op == OP_CFG)    return SEL_CFG;
        else if (op == OP_BYPASS) return SEL_BYP;
        else                      return SEL_BYP;
    endfunction

    logic [IR_W-1:0] ir_q, ir_d, ir_sh, ir_cap;
    logic [ID_W-1:0] id_sh;
    logic            byp_q;
    dr_sel_e         sel;

    always_comb begin
        ir_cap    = '0;
        ir_cap[0] = 1'b1;
        ir_cap[3] = st_secure;
        ir_cap[4] = st_prog;
    end

    always_comb begin
        if (state == TAP_TLR)         ir_d = OP_IDCODE;
        else if (state == TAP_UPD_IR) ir_d = ir_sh;
        else                          ir_d = ir_q;
    end

    assign sel = decode(ir_q);

    always_ff @(posedge tck) begin
        if (trst) begin
            ir_q    <= OP_IDCODE;
            ir_sh   <= '0;
            id_sh   <= '0;
            byp_q   <= 1'b0;
            cfg_req <= 1'b0;
        end else begin
            ir_q <= ir_d;
            if (state == TAP_CAP_IR)     ir_sh <= ir_cap;
            else if (state == TAP_SH_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            if (sel == SEL_ID) begin
                if (state == TAP_CAP_DR)     id_sh <= ID_VAL;
                else if (state == TAP_SH_DR) id_sh <= {tdi, id_sh[ID_W-1:1]};
            end
            if (state == TAP_CAP_DR)     byp_q <= 1'b0;
            else if (state == TAP_SH_DR) byp_q <= tdi;
            cfg_req <= (nxt == TAP_RTI) && (decode(ir_d) == SEL_CFG);
        end
    end

    always_ff @(negedge tck) begin
        if (trst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state == TAP_SH_IR) || (state == TAP_SH_DR);
            if (state == TAP_SH_IR)      tdo <= ir_sh[0];
            else if (state == TAP_SH_DR) tdo <= (sel == SEL_ID) ? id_sh[0] : byp_q;
        end
    end

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (trst)
        state == TAP_CAP_IR |=> ir_sh[2:0] == 3'b001 && ir_sh[3] == $past(st_secure)
                                && ir_sh[4] == $past(st_prog))
        else $error("instruction capture value wrong");

    // R5
    byp_capture_chk: assert property (@(posedge tck) disable iff (trst)
        state == TAP_CAP_DR |=> !byp_q)
        else $error("bypass did not capture zero");

    // R7
    tdo_oe_chk: assert property (@(posedge tck) disable iff (trst)
        tdo_oe == ((state == TAP_SH_IR) || (state == TAP_SH_DR)))
        else $error("TDO enable outside shift states");

endmodule

// File: rtl/cfg_pulse.sv
module cfg_pulse #(
    parameter int PULSE_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic cfg_n
);

    localparam int CW = $clog2(PULSE_CYC + 1);

    logic [2:0]    sync_q;
    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic          start;

    assign start = sync_q[1] && !sync_q[2];
    assign cfg_n = !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[1:0], req};
            if (busy_q) begin
                if (cnt_q == '0) busy_q <= 1'b0;
                else             cnt_q  <= cnt_q - 1'b1;
            end else if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(PULSE_CYC - 1);
            end
        end
    end

    // R8
    pulse_count_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && cnt_q != '0 |=> busy_q && cnt_q == $past(cnt_q) - 1'b1)
        else $error("restart pulse counter stalled or cut short");

    // R8
    pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && cnt_q == '0 |=> !busy_q)
        else $error("restart pulse overran");

endmodule

// File: rtl/cfg_tap.sv
module cfg_tap
    import cfgtap_pkg::*;
#(
    parameter int              IR_W      = 8,
    parameter logic [IR_W-1:0] OP_IDCODE = 8'h09,
    parameter logic [IR_W-1:0] OP_CFG    = 8'hEE,
    parameter logic [IR_W-1:0] OP_BYPASS = '1,
    parameter logic [3:0]      ID_VER    = 4'h3,
    parameter logic [7:0]      ID_FAM    = 8'h5C,
    parameter logic [7:0]      ID_PROD   = 8'h21,
    parameter logic [10:0]     ID_MAKER  = 11'h2A5,
    parameter int              PULSE_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic tck,
    input  logic trst,
    input  logic tms,
    input  logic tdi,
    input  logic st_secure,
    input  logic st_prog,
    output logic tdo,
    output logic tdo_oe,
    output logic cfg_n
);

    localparam idword_t ID_WORD = '{ver: ID_VER, fam: ID_FAM, prod: ID_PROD,
                                    maker: ID_MAKER, one: 1'b1};

    tap_st_e state, nxt;
    logic    cfg_req;

    tap_fsm u_fsm (
        .tck   (tck),
        .trst  (trst),
        .tms   (tms),
        .state (state),
        .nxt   (nxt)
    );

    tap_regs #(
        .IR_W      (IR_W),
        .OP_IDCODE (OP_IDCODE),
        .OP_CFG    (OP_CFG),
        .OP_BYPASS (OP_BYPASS),
        .ID_VAL    (ID_WORD)
    ) u_regs (
        .tck       (tck),
        .trst      (trst),
        .tdi       (tdi),
        .state     (state),
        .nxt       (nxt),
        .st_secure (st_secure),
        .st_prog   (st_prog),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe),
        .cfg_req   (cfg_req)
    );

    cfg_pulse #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .req   (cfg_req),
        .cfg_n (cfg_n)
    );

endmodule

// File: tb/cfg_tap_tb.sv
module cfg_tap_tb;

    localparam int   PULSE = 40;
    localparam logic [7:0] OP_ID  = 8'h09;
    localparam logic [7:0] OP_CF  = 8'hEE;
    localparam logic [31:0] ID_EXP = {4'h3, 8'h5C, 8'h21, 11'h2A5, 1'b1};

    logic clk = 1'b0;
    logic rst, tck, trst, tms, tdi, st_secure, st_prog;
    logic tdo, tdo_oe, cfg_n;

    int n_run  = 0;
    int n_fail = 0;
    int pulses = 0;
    int low_run = 0;
    int last_len = 0;
    logic prev_cfg = 1'b1;
    logic last_oe;

    always #5 clk = ~clk;

    cfg_tap u_dut (
        .clk (clk), .rst (rst), .tck (tck), .trst (trst), .tms (tms), .tdi (tdi),
        .st_secure (st_secure), .st_prog (st_prog),
        .tdo (tdo), .tdo_oe (tdo_oe), .cfg_n (cfg_n)
    );

    // observe restart pulses on the system clock
    always @(negedge clk) begin
        if (!rst) begin
            if (!cfg_n) low_run = low_run + 1;
            if (prev_cfg && !cfg_n) pulses = pulses + 1;
            if (!prev_cfg && cfg_n) begin
                last_len = low_run;
                low_run  = 0;
            end
            prev_cfg = cfg_n;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tc(input logic m, input logic d, output logic o);
        tms = m;
        tdi = d;
        #20;
        o = tdo;
        last_oe = tdo_oe;
        #5 tck = 1'b1;
        #50 tck = 1'b0;
        #25;
    endtask

    task automatic idle(input int n);
        logic b;
        for (int i = 0; i < n; i++) tc(1'b0, 1'b0, b);
    endtask

    // RTI -> shift IR -> RTI, returns captured word
    task automatic load_ir(input logic [7:0] op, output logic [7:0] cap);
        logic b;
        tc(1, 0, b); tc(1, 0, b); tc(0, 0, b); tc(0, 0, b);
        for (int i = 0; i < 8; i++) begin
            tc(i == 7, op[i], b);
            cap[i] = b;
        end
        tc(1, 0, b); tc(0, 0, b);
    endtask

    // RTI -> shift DR n bits -> RTI
    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout,
                           output logic oe_all);
        logic b;
        dout = '0;
        oe_all = 1'b1;
        tc(1, 0, b); tc(0, 0, b); tc(0, 0, b);
        for (int i = 0; i < n; i++) begin
            tc(i == n - 1, din[i], b);
            dout[i] = b;
            oe_all = oe_all & last_oe;
        end
        tc(1, 0, b); tc(0, 0, b);
    endtask

    task automatic t_reset;
        logic [63:0] d;
        logic oe;
        logic b;
        chk(cfg_n === 1'b1, "R9 cfg_n after reset", cfg_n, 1);
        chk(tdo_oe === 1'b0, "R7 tdo_oe after reset", tdo_oe, 0);
        tc(0, 0, b);
        chk(last_oe === 1'b0, "R7 tdo_oe in idle", last_oe, 0);
        scan_dr(32, 64'h0, d, oe);
        chk(d[31:0] == ID_EXP, "R1 identification after test reset", d[31:0], ID_EXP);
        chk(oe === 1'b1, "R7 tdo_oe during shift", oe, 1);
    endtask

    task automatic t_idcode;
        logic [63:0] d;
        logic oe;
        scan_dr(40, 64'h0000_00A7_0000_0000 >> 32, d, oe);
        chk(d[31:0] == ID_EXP, "R4 identification layout", d[31:0], ID_EXP);
        chk(d[39:32] == 8'hA7, "R4 TDI follows word", d[39:32], 8'hA7);
    endtask

    task automatic t_capture;
        logic [7:0] c;
        logic [7:0] dummy;
        st_secure = 1'b1; st_prog = 1'b0;
        load_ir(OP_ID, c);
        chk(c == 8'b0000_1001, "R3 capture secure", c, 8'b0000_1001);
        st_secure = 1'b0; st_prog = 1'b1;
        load_ir(OP_ID, c);
        chk(c == 8'b0001_0001, "R3 capture prog", c, 8'b0001_0001);
        st_secure = 1'b1; st_prog = 1'b1;
        load_ir(OP_ID, c);
        chk(c == 8'b0001_1001, "R3 capture both", c, 8'b0001_1001);
        st_secure = 1'b0; st_prog = 1'b0;
        load_ir(OP_ID, dummy);
    endtask

    task automatic t_bypass(input logic [7:0] op, input string req);
        logic [7:0] c;
        logic [63:0] d;
        logic oe;
        load_ir(op, c);
        scan_dr(8, 64'hB5, d, oe);
        chk(d[7:0] == 8'h6A, req, d[7:0], 8'h6A);
    endtask

    task automatic t_tms_home;
        logic [7:0] c;
        logic [63:0] d;
        logic oe;
        logic b;
        load_ir(8'hFF, c);
        tc(1, 0, b); tc(0, 0, b); tc(0, 0, b); tc(0, 1, b); tc(0, 0, b);
        for (int i = 0; i < 5; i++) tc(1, 0, b);
        chk(tdo_oe === 1'b0, "R2 no shift after TMS reset", tdo_oe, 0);
        tc(0, 0, b);
        scan_dr(32, 64'h0, d, oe);
        chk(d[31:0] == ID_EXP, "R2 identification restored", d[31:0], ID_EXP);
    endtask

    task automatic t_config;
        logic [7:0] c;
        logic [63:0] d;
        logic oe;
        int p0;
        p0 = pulses;
        load_ir(OP_CF, c);
        idle(10);
        chk(pulses == p0 + 1, "R8 one pulse on entry", pulses, p0 + 1);
        chk(last_len == PULSE, "R8 pulse length", last_len, PULSE);
        idle(10);
        chk(pulses == p0 + 1, "R8 no repeat while idle", pulses, p0 + 1);
        scan_dr(1, 64'h0, d, oe);
        idle(10);
        chk(pulses == p0 + 2, "R8 re-entry pulses again", pulses, p0 + 2);
        chk(last_len == PULSE, "R8 second pulse length", last_len, PULSE);
        chk(cfg_n === 1'b1, "R8 cfg_n released", cfg_n, 1);
    endtask

    task automatic t_no_config;
        logic [7:0] c;
        logic [63:0] d;
        logic oe;
        int p0;
        p0 = pulses;
        load_ir(OP_ID, c);
        scan_dr(32, 64'h0, d, oe);
        idle(10);
        chk(pulses == p0, "R9 no pulse for other instruction", pulses, p0);
        chk(cfg_n === 1'b1, "R9 cfg_n stays high", cfg_n, 1);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic b;
        tck = 1'b0; tms = 1'b0; tdi = 1'b0; rst = 1'b1; trst = 1'b1;
        st_secure = 1'b0; st_prog = 1'b0;
        #2;
        for (int i = 0; i < 3; i++) tc(0, 0, b);
        rst = 1'b0;
        trst = 1'b0;
        t_reset();
        t_idcode();
        t_capture();
        t_bypass(8'hFF, "R5 all-ones bypass");
        t_bypass(8'h5A, "R6 unknown opcode bypass");
        t_tms_home();
        t_config();
        t_no_config();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule